// File: doc/BRIEF.md
# Byte-Buffered 16-bit Timer/Event Counter

This block is a 16-bit up-counter reached through an 8-bit register bus. A 16-bit value has to cross that bus one byte at a time, so the block keeps one shared low-byte holding register. Software writes the low byte first and the high byte second. The high-byte write commits all 16 bits to the reload register in one cycle. To read, software reads the high byte first, which copies the live low byte into the holding register in the same cycle. The low-byte read that follows returns that frozen copy, so the two halves always belong to the same count.

The count advances on one of three sources:
- the system clock divided by four;
- an externally supplied time-base tick;
- an external event pin, sampled through a two-stage synchronizer, counted on a selectable edge.

In pulse-width mode, internal ticks are counted only while the pin sits at its active level. The counter reloads from the reload register in two cases: when counting is switched on, and when it passes 0xFFFF. The rollover also sets a sticky flag, which software can read and clear.

Top module: `evt_timer16`

## Requirements
- R1: After reset, every register of the block reads 0x00: the holding byte (address 0), the counter high byte (address 1) and control (address 2).
- R2: A write to address 0 changes only the holding byte; the 16-bit reload value stays as it was.
- R3: A write to address 1 loads the reload value with the written byte as bits 15:8 and the holding byte as bits 7:0, in that same cycle.
- R4: A read of address 1 returns bits 15:8 of the counter. In the same cycle it copies bits 7:0 into the holding byte. If a count step falls in that cycle, both halves are taken from the value before the step.
- R5: A read of address 0 returns the holding byte, never the live counter low byte.
- R6: Control fields are: bits 1:0 mode, bit 2 enable, bit 3 edge/level select, bit 4 source select, bit 7 overflow flag; bits 6:5 read 0. A control write that takes enable from 0 to 1 loads the counter from the reload value. A control write with enable already 1 does not reload.
- R7: Mode 2'b10 (timer) with source bit 0 advances the counter once every 4 system clocks, the first step 4 clocks after enable.
- R8: Mode 2'b10 with source bit 1 advances the counter once per cycle in which the time-base tick input is high.
- R9: Mode 2'b01 (event) counts edges of the external pin after a two-flip-flop synchronizer: rising edges when bit 3 is 0, falling edges when bit 3 is 1. Pulses of two clocks or longer are counted.
- R10: Mode 2'b11 (pulse width) counts internal ticks (selected by bit 4) only while the synchronized pin is high (bit 3 = 0) or low (bit 3 = 1).
- R11: A count step from 0xFFFF loads the reload value and sets the overflow flag. The flag stays set until a control write with bit 7 = 0 clears it; writing 1 to bit 7 has no effect. A rollover in the same cycle as a clearing write leaves the flag set.
- R12: Mode 2'b00 holds the counter regardless of ticks or pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 1) |
| bus_addr | input | 2 | Register address: 0 holding byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| base_tick | input | 1 | Alternate time-base tick, one clock wide, synchronous to clk |
| ext_evt | input | 1 | Asynchronous external event/gate pin |

## Verification
The two operations that can coincide are a high-byte read and a count step. The step may carry from the low byte into the high byte. The bench sets the counter to 0x12FF with the tick source selected, then raises the read strobe and the tick in the same cycle. The high byte returned and the low byte read back afterwards must both come from 0x12FF; a frozen re-read must then show 0x1300. A second collision pairs a rollover with a flag-clearing control write; here the flag must still read as set afterwards.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

  typedef enum logic [1:0] {
    MODE_STOP  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } et_mode_e;

  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_MODE_LSB = 0;
  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_EDGE_BIT = 3;
  localparam int CTRL_SRC_BIT  = 4;
  localparam int CTRL_OVF_BIT  = 7;

endpackage

// File: rtl/et_regs.sv
module et_regs
  import evt_timer16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [1:0]          addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [2*BYTE_W-1:0] count_i,
  input  logic                ovf_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic [2*BYTE_W-1:0] preload_o,
  output et_mode_e            mode_o,
  output logic                en_o,
  output logic                edge_o,
  output logic                src_o,
  output logic                en_rise_o,
  output logic                ovf_clr_o
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0]  pre_q, pre_d;
  et_mode_e          mode_q, mode_d;
  logic              en_q, en_d;
  logic              edge_q, edge_d;
  logic              src_q, src_d;

  logic wr_low, wr_high, wr_ctrl, rd_high;
  logic [BYTE_W-1:0] ctrl_rd;
  logic ctrl_unused;

  assign wr_low  = wr_i && (addr_i == ADDR_LOW);
  assign wr_high = wr_i && (addr_i == ADDR_HIGH);
  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign rd_high = rd_i && !wr_i && (addr_i == ADDR_HIGH);
  assign ctrl_unused = ^wdata_i[CTRL_OVF_BIT-1:CTRL_SRC_BIT+1];

  // Next-state logic
  always_comb begin
    hold_d = hold_q;
    if (wr_low)
      hold_d = wdata_i;
    else if (rd_high)
      hold_d = count_i[BYTE_W-1:0];

    pre_d = pre_q;
    if (wr_high)
      pre_d = {wdata_i, hold_q};

    mode_d = mode_q;
    en_d   = en_q;
    edge_d = edge_q;
    src_d  = src_q;
    if (wr_ctrl) begin
      mode_d = et_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
      en_d   = wdata_i[CTRL_EN_BIT];
      edge_d = wdata_i[CTRL_EDGE_BIT];
      src_d  = wdata_i[CTRL_SRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pre_q  <= '0;
      mode_q <= MODE_STOP;
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pre_q  <= pre_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      edge_q <= edge_d;
      src_q  <= src_d;
    end
  end

  assign en_rise_o = wr_ctrl && wdata_i[CTRL_EN_BIT] && !en_q;
  assign ovf_clr_o = wr_ctrl && !wdata_i[CTRL_OVF_BIT];

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_MODE_LSB +: 2] = mode_q;
    ctrl_rd[CTRL_EN_BIT]        = en_q;
    ctrl_rd[CTRL_EDGE_BIT]      = edge_q;
    ctrl_rd[CTRL_SRC_BIT]       = src_q;
    ctrl_rd[CTRL_OVF_BIT]       = ovf_i;
  end

  always_comb begin
    case (addr_i)
      ADDR_LOW:  rdata_o = hold_q;
      ADDR_HIGH: rdata_o = count_i[CNT_W-1:BYTE_W];
      ADDR_CTRL: rdata_o = ctrl_rd;
      default:   rdata_o = '0;
    endcase
  end

  assign preload_o = pre_q;
  assign mode_o    = mode_q;
  assign en_o      = en_q;
  assign edge_o    = edge_q;
  assign src_o     = src_q;

  // R2: low-byte write leaves the reload value untouched
  p_low_keeps_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_low |=> $stable(pre_q));

  // R3: high-byte write commits both halves at once
  p_commit_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_high |=> (pre_q == {$past(wdata_i), $past(hold_q)}));

  // R4: high-byte read snapshots the counter low byte of that cycle
  p_snapshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_high |=> (hold_q == $past(count_i[BYTE_W-1:0])));

endmodule

// File: rtl/et_source.sv
module et_source
  import evt_timer16_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_i,
  input  logic     tick_i,
  input  et_mode_e mode_i,
  input  logic     en_i,
  input  logic     edge_i,
  input  logic     src_i,
  input  logic     restart_i,
  output logic     step_o
);

  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [PW-1:0]          pre_q, pre_d;

  logic lvl, edge_rise, edge_fall, edge_hit, active, div_tick, int_tick;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ext_i};
    prev_d = sync_q[SYNC_STAGES-1];

    pre_d = pre_q;
    if (restart_i)
      pre_d = '0;
    else if (en_i)
      pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      pre_q  <= pre_d;
    end
  end

  assign lvl       = sync_q[SYNC_STAGES-1];
  assign edge_rise = lvl && !prev_q;
  assign edge_fall = !lvl && prev_q;
  assign edge_hit  = edge_i ? edge_fall : edge_rise;
  assign active    = lvl ^ edge_i;
  assign div_tick  = en_i && (pre_q == PRE_LAST);
  assign int_tick  = src_i ? tick_i : div_tick;

  always_comb begin
    step_o = 1'b0;
    if (en_i) begin
      case (mode_i)
        MODE_EVENT: step_o = edge_hit;
        MODE_TIMER: step_o = int_tick;
        MODE_PULSE: step_o = int_tick && active;
        default:    step_o = 1'b0;
      endcase
    end
  end

  // R7: divided ticks are never back to back
  p_div_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick);

  // R9: a detected rising edge reflects the pin two clocks earlier
  p_sync_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |-> $past(ext_i, SYNC_STAGES));

endmodule

// File: rtl/et_core.sv
module et_core
  import evt_timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             ovf_clr_i,
  input  et_mode_e         mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, count_d;
  logic             ovf_q, ovf_d;
  logic             wrap;

  always_comb begin
    count_d = count_q;
    wrap    = 1'b0;
    if (load_i) begin
      count_d = preload_i;
    end else if (step_i) begin
      if (count_q == CNT_MAX) begin
        count_d = preload_i;
        wrap    = 1'b1;
      end else begin
        count_d = count_q + 1'b1;
      end
    end

    ovf_d = ovf_q;
    if (wrap)
      ovf_d = 1'b1;
    else if (ovf_clr_i)
      ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;

  // R6: enable rising reloads the counter
  p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(preload_i)));

  // R11: rollover reloads and raises the flag
  p_wrap_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && count_q == CNT_MAX) |=> (count_q == $past(preload_i) && ovf_q));

  // R11: flag is sticky until a clearing write
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R12: stopped mode holds the count
  p_stop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_STOP && !load_i) |=> $stable(count_q));

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              base_tick,
  input  logic              ext_evt
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] count, preload;
  logic             ovf, en, edge_sel, src_sel, en_rise, ovf_clr, step;
  et_mode_e         mode;

  et_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr),
    .rd_i      (bus_rd),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .count_i   (count),
    .ovf_i     (ovf),
    .rdata_o   (bus_rdata),
    .preload_o (preload),
    .mode_o    (mode),
    .en_o      (en),
    .edge_o    (edge_sel),
    .src_o     (src_sel),
    .en_rise_o (en_rise),
    .ovf_clr_o (ovf_clr)
  );

  et_source #(.SYNC_STAGES(SYNC_STAGES), .PRE_DIV(PRE_DIV)) u_source (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_i     (ext_evt),
    .tick_i    (base_tick),
    .mode_i    (mode),
    .en_i      (en),
    .edge_i    (edge_sel),
    .src_i     (src_sel),
    .restart_i (en_rise),
    .step_o    (step)
  );

  et_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step),
    .load_i    (en_rise),
    .preload_i (preload),
    .ovf_clr_i (ovf_clr),
    .mode_i    (mode),
    .count_o   (count),
    .ovf_o     (ovf)
  );

endmodule

// File: tb/tb_evt_timer16.sv
module tb_evt_timer16;

  logic       clk;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       base_tick;
  logic       ext_evt;

  int checks = 0;
  int errors = 0;

  evt_timer16 dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .base_tick (base_tick),
    .ext_evt   (ext_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] pack16(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic ovf, input logic src, input logic edg,
                                           input logic en, input logic [1:0] mode);
    return {ovf, 2'b00, src, edg, en, mode};
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(2'd1, h);
    bus_read(2'd0, l);
    v = pack16(h, l);
  endtask

  task automatic set_preload(input logic [15:0] p);
    bus_write(2'd0, p[7:0]);
    bus_write(2'd1, p[15:8]);
  endtask

  task automatic tick_once();
    @(negedge clk);
    base_tick = 1'b1;
    @(posedge clk); #1;
    base_tick = 1'b0;
  endtask

  task automatic ext_pulse(input int hi, input int lo);
    @(negedge clk);
    ext_evt = 1'b1;
    repeat (hi) @(negedge clk);
    ext_evt = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0]  v8, lo, hi, x;
    logic [15:0] v16, pre_m;
    logic [7:0]  hold_m;

    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0;
    bus_wdata = 8'h00; base_tick = 1'b0; ext_evt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    bus_read(2'd0, v8); check("R1", "holding byte", {8'h0, v8}, 16'h0000);
    bus_read(2'd1, v8); check("R1", "high byte", {8'h0, v8}, 16'h0000);
    bus_read(2'd2, v8); check("R1", "control", {8'h0, v8}, 16'h0000);

    // R5 / R2: low write goes to holding byte only
    bus_write(2'd0, 8'h5A);
    bus_read(2'd0, v8); check("R5", "low read gives buffer", {8'h0, v8}, 16'h005A);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b00));
    read16(v16); check("R2", "preload untouched by low write", v16, 16'h0000);

    // Random byte-pair traffic
    for (int i = 0; i < 40; i++) begin
      lo = 8'($urandom); hi = 8'($urandom);
      bus_write(2'd0, lo);
      bus_write(2'd1, hi);
      pre_m = pack16(hi, lo); hold_m = lo;
      if ($urandom % 2 == 1) begin
        x = 8'($urandom);
        bus_write(2'd0, x);
        hold_m = x;
      end
      bus_read(2'd0, v8); check("R5", "random holding byte", {8'h0, v8}, {8'h0, hold_m});
      bus_write(2'd2, 8'h00);
      bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b00));
      bus_read(2'd1, v8); check("R3", "random committed high", {8'h0, v8}, {8'h0, pre_m[15:8]});
      bus_read(2'd0, v8); check("R2", "random committed low", {8'h0, v8}, {8'h0, pre_m[7:0]});
    end

    // R6: enable already set does not reload
    bus_write(2'd2, 8'h00);
    set_preload(16'hA1B2);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b00));
    set_preload(16'h3344);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b00));
    read16(v16); check("R6", "no reload while enabled", v16, 16'hA1B2);

    // R7: divide-by-4 timer
    bus_write(2'd2, 8'h00);
    set_preload(16'h0100);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b10));
    repeat (40) @(posedge clk);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b00));
    read16(v16); check("R7", "40 clocks at div4", v16, 16'h010A);

    // R8: time-base tick source
    bus_write(2'd2, 8'h00);
    set_preload(16'h2000);
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b10));
    repeat (7) tick_once();
    repeat (5) @(posedge clk);
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b00));
    read16(v16); check("R8", "seven ticks", v16, 16'h2007);

    // R4: high read collides with a carrying step
    bus_write(2'd2, 8'h00);
    set_preload(16'h12FF);
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b10));
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; base_tick = 1'b1;
    #1 v8 = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0; base_tick = 1'b0;
    check("R4", "high byte before carry", {8'h0, v8}, 16'h0012);
    bus_read(2'd0, v8); check("R4", "snapshot low before step", {8'h0, v8}, 16'h00FF);
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b00));
    read16(v16); check("R4", "count after step", v16, 16'h1300);

    // R11: rollover, sticky flag, clear, set-wins collision
    bus_write(2'd2, 8'h00);
    set_preload(16'hFFFE);
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b10));
    tick_once(); tick_once();
    bus_read(2'd2, v8); check("R11", "flag after rollover", {8'h0, v8}, 16'h0096);
    read16(v16); check("R11", "reload on rollover", v16, 16'hFFFE);
    bus_write(2'd2, 8'h96);
    bus_read(2'd2, v8); check("R11", "writing 1 keeps flag", {8'h0, v8}, 16'h0096);
    bus_write(2'd2, 8'h16);
    bus_read(2'd2, v8); check("R11", "writing 0 clears flag", {8'h0, v8}, 16'h0016);
    tick_once();
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = 8'h16; bus_wr = 1'b1; base_tick = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; base_tick = 1'b0;
    bus_read(2'd2, v8); check("R11", "set beats clear", {8'h0, v8}, 16'h0096);
    read16(v16); check("R11", "count after colliding wrap", v16, 16'hFFFE);

    // R9: event counting, rising then falling
    bus_write(2'd2, 8'h00);
    set_preload(16'h0000);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b01));
    repeat (5) ext_pulse(3, 3);
    repeat (6) @(posedge clk);
    bus_write(2'd2, ctrl_byte(0, 0, 0, 1, 2'b00));
    read16(v16); check("R9", "rising edges", v16, 16'h0005);
    bus_write(2'd2, 8'h00);
    bus_write(2'd2, ctrl_byte(0, 0, 1, 1, 2'b01));
    repeat (3) ext_pulse(2, 2);
    repeat (6) @(posedge clk);
    bus_write(2'd2, ctrl_byte(0, 0, 1, 1, 2'b00));
    read16(v16); check("R9", "falling edges, 2-clock pulses", v16, 16'h0003);

    // R10: pulse-width, active high then active low
    bus_write(2'd2, 8'h00);
    ext_evt = 1'b0;
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b11));
    repeat (3) tick_once();
    @(negedge clk) ext_evt = 1'b1;
    repeat (4) @(posedge clk);
    repeat (5) tick_once();
    @(negedge clk) ext_evt = 1'b0;
    repeat (4) @(posedge clk);
    repeat (2) tick_once();
    bus_write(2'd2, ctrl_byte(0, 1, 0, 1, 2'b00));
    read16(v16); check("R10", "ticks while high", v16, 16'h0005);
    bus_write(2'd2, 8'h00);
    @(negedge clk) ext_evt = 1'b1;
    repeat (4) @(posedge clk);
    bus_write(2'd2, ctrl_byte(0, 1, 1, 1, 2'b11));
    repeat (3) tick_once();
    @(negedge clk) ext_evt = 1'b0;
    repeat (4) @(posedge clk);
    repeat (4) tick_once();
    @(negedge clk) ext_evt = 1'b1;
    repeat (4) @(posedge clk);
    repeat (2) tick_once();
    bus_write(2'd2, ctrl_byte(0, 1, 1, 1, 2'b00));
    read16(v16); check("R10", "ticks while low", v16, 16'h0004);

    // R12: stopped mode ignores all sources
    repeat (3) tick_once();
    repeat (2) ext_pulse(3, 3);
    repeat (12) @(posedge clk);
    read16(v16); check("R12", "stopped count held", v16, 16'h0004);

    finish_run();
  end

endmodule